// File: doc/BRIEF.md
# Banked Cartridge Address Mapper

This block sits between a CPU write bus and two memory address buses of a cartridge. It splits the upper 32K of CPU space into four 8K program windows and the 8K video pattern space into eight 1K character slots. For each access it turns the incoming address into a banked ROM or RAM address. The bank numbers come from a small register file that the CPU loads with plain writes into the upper 32K. The block also drives the nametable mirroring choice to the video side.

One select register names which of eight bank registers the next data write fills. The same select register holds two mode bits. The first mode bit swaps the switchable program window with the fixed second-to-last one. The second mode bit swaps which character half holds the two 2K pairs and which half holds the four 1K slots. Both translations are combinational from the current address and the stored registers, so a register write affects the translation from the cycle after it.

Top module: `cart_bank_map`

## Requirements
- R1: Only CPU address bits 15, 14, 13 and 0 select a register. Any address in 0x8000-0xFFFF that has the same values in those four bits reaches the same register as its base address (for example, 0x9FFE acts as 0x8000, 0x9FFF acts as 0x8001 and 0xBFFE acts as 0xA000).
- R2: A write to 0x8000 stores the select byte. Bits 2:0 are the target register index, bit 6 is the program mode and bit 7 is the character inversion flag.
- R3: A write to 0x8001 stores the data byte in the bank register named by select bits 2:0.
- R4: In program mode 0, the four windows 0x8000, 0xA000, 0xC000 and 0xE000 use, in that order: register 6, register 7, the second-to-last bank and the last bank. The ROM address is the bank number joined to CPU address bits 12:0.
- R5: In program mode 1, window 0x8000 uses the second-to-last bank and window 0xC000 uses register 6. Window 0xA000 still uses register 7, and window 0xE000 still uses the last bank.
- R6: With inversion 0, slots 0 and 1 use register 0 with bit 0 forced to 0 and then to 1. Slots 2 and 3 use register 1 in the same way. Slots 4 to 7 use registers 2 to 5. The slot is video address bits 12:10, and the character address is the bank joined to video bits 9:0.
- R7: With inversion 1, slots 0 to 3 use registers 2 to 5. Slots 4-5 take the pair from register 0, and slots 6-7 take the pair from register 1.
- R8: A write to 0xA000 sets the mirroring output from data bit 0 (1 = horizontal, 0 = vertical).
- R9: While the four-screen configuration input is high, writes to 0xA000 leave the mirroring output unchanged.
- R10: Writes to 0xA001 and to any address in 0xC000-0xFFFF change no mapping and no mirroring.
- R11: Reset clears the select byte, all eight bank registers and the mirroring output. After reset the windows read banks 0, 0, second-to-last and last, and every character slot reads bank 0 or 1.
- R12: CPU addresses 0x6000-0x7FFF raise the RAM select and give address bits 12:0 as the RAM address. Addresses 0x8000-0xFFFF raise the ROM select. Writes below 0x8000 touch no register.
- R13: Bank numbers are reduced to their low log2(bank count) bits. The program count is 16 by default and the character count is 128 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuWrEn | input | 1 | CPU write strobe for the current cycle |
| cpuAddr | input | 16 | CPU address, used for both decode and translation |
| cpuData | input | 8 | CPU write data |
| fourScreenCfg | input | 1 | Cartridge strapped for four-screen nametables |
| vidAddr | input | 13 | Video pattern-space address |
| prgRomSel | output | 1 | CPU address falls in the ROM windows |
| prgRomAddr | output | log2(PRG_BANKS)+13 | Banked program ROM address |
| prgRamSel | output | 1 | CPU address falls in the RAM window |
| prgRamAddr | output | 13 | Program RAM address |
| chrAddr | output | log2(CHR_BANKS)+10 | Banked character address |
| mirrorHorz | output | 1 | 1 = horizontal mirroring, 0 = vertical |

## Verification
The hardest state to reach is one where both mode bits and all eight registers hold distinct, non-trivial values at the same time. Only then does a wrong window or slot choice show up as a wrong address rather than a coincidental match. The stimulus loads every register with a different value, including one wider than the bank count, and then flips each mode bit with a select write that leaves the data untouched. Mirror-image addresses such as 0x9FFF and 0xBFFE reach the registers without using the base addresses. Writes to the interrupt-range addresses and to 0xA001 are placed between probes, so that any stray effect appears on the very next translation.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
  // decode key = {cpuAddr[14:13], cpuAddr[0]}
  localparam logic [2:0] KEY_SELECT = 3'b000;
  localparam logic [2:0] KEY_DATA   = 3'b001;
  localparam logic [2:0] KEY_MIRROR = 3'b010;

  localparam int SEL_MODE_BIT = 6;
  localparam int SEL_INV_BIT  = 7;
  localparam int NUM_BANK_REGS = 8;

  typedef struct packed {
    logic       selWr;
    logic       dataWr;
    logic       mirWr;
    logic [7:0] wdata;
  } ctrlStrobes_t;
endpackage

// File: rtl/cbm_ctrl.sv
module cbm_ctrl
  import cbm_pkg::*;
(
  input  logic         cpuWrEn,
  input  logic [15:0]  cpuAddr,
  input  logic [7:0]   cpuData,
  input  logic         fourScreenCfg,
  output ctrlStrobes_t strobes
);
  logic [2:0] regKey;
  logic       upperWrite;

  assign regKey     = {cpuAddr[14:13], cpuAddr[0]};
  assign upperWrite = cpuWrEn && cpuAddr[15];

  always_comb begin
    strobes        = '0;
    strobes.wdata  = cpuData;
    if (upperWrite) begin
      unique case (regKey)
        KEY_SELECT: strobes.selWr  = 1'b1;
        KEY_DATA:   strobes.dataWr = 1'b1;
        KEY_MIRROR: strobes.mirWr  = !fourScreenCfg;
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/cbm_dpath.sv
module cbm_dpath
  import cbm_pkg::*;
#(
  parameter int PRG_BANKS = 16,
  parameter int CHR_BANKS = 128
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctrlStrobes_t                 strobes,
  input  logic [15:0]                  cpuAddr,
  input  logic [12:0]                  vidAddr,
  output logic                         prgRomSel,
  output logic [$clog2(PRG_BANKS)+12:0] prgRomAddr,
  output logic                         prgRamSel,
  output logic [12:0]                  prgRamAddr,
  output logic [$clog2(CHR_BANKS)+9:0] chrAddr,
  output logic                         mirrorHorz
);
  localparam int PBW = $clog2(PRG_BANKS);
  localparam int CBW = $clog2(CHR_BANKS);
  localparam logic [PBW-1:0] LAST_BANK   = '1;
  localparam logic [PBW-1:0] SECOND_LAST = LAST_BANK - 1'b1;

  logic [2:0] selIdx;
  logic       prgMode;
  logic       chrInv;
  logic       mirReg;
  logic [7:0] bankReg [NUM_BANK_REGS];

  // select register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selIdx  <= '0;
      prgMode <= 1'b0;
      chrInv  <= 1'b0;
    end else if (strobes.selWr) begin
      selIdx  <= strobes.wdata[2:0];
      prgMode <= strobes.wdata[SEL_MODE_BIT];
      chrInv  <= strobes.wdata[SEL_INV_BIT];
    end
  end

  // bank data registers
  for (genvar g = 0; g < NUM_BANK_REGS; g++) begin : gBank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        bankReg[g] <= '0;
      else if (strobes.dataWr && (selIdx == 3'(g)))
        bankReg[g] <= strobes.wdata;
    end
  end

  // mirroring register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      mirReg <= 1'b0;
    else if (strobes.mirWr)
      mirReg <= strobes.wdata[0];
  end
  assign mirrorHorz = mirReg;

  // program windows
  logic [1:0]     prgWin;
  logic [PBW-1:0] prgBank;
  assign prgWin = cpuAddr[14:13];

  always_comb begin
    unique case (prgWin)
      2'd0:    prgBank = prgMode ? SECOND_LAST : bankReg[6][PBW-1:0];
      2'd1:    prgBank = bankReg[7][PBW-1:0];
      2'd2:    prgBank = prgMode ? bankReg[6][PBW-1:0] : SECOND_LAST;
      default: prgBank = LAST_BANK;
    endcase
  end

  assign prgRomSel  = cpuAddr[15];
  assign prgRomAddr = {prgBank, cpuAddr[12:0]};
  assign prgRamSel  = (cpuAddr[15:13] == 3'b011);
  assign prgRamAddr = cpuAddr[12:0];

  // character slots: inversion flips which half is the 2K half
  logic [2:0]     effSlot;
  logic [2:0]     oneKIdx;
  logic [7:0]     pairReg;
  logic [CBW-1:0] chrBank;

  assign effSlot = vidAddr[12:10] ^ {chrInv, 2'b00};
  assign oneKIdx = {1'b0, effSlot[1:0]} + 3'd2;
  assign pairReg = bankReg[{2'b00, effSlot[1]}];

  always_comb begin
    if (!effSlot[2])
      chrBank = {pairReg[CBW-1:1], effSlot[0]};
    else
      chrBank = bankReg[oneKIdx][CBW-1:0];
  end

  assign chrAddr = {chrBank, vidAddr[9:0]};
endmodule

// File: rtl/cart_bank_map.sv
module cart_bank_map
  import cbm_pkg::*;
#(
  parameter int PRG_BANKS = 16,
  parameter int CHR_BANKS = 128
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          cpuWrEn,
  input  logic [15:0]                   cpuAddr,
  input  logic [7:0]                    cpuData,
  input  logic                          fourScreenCfg,
  input  logic [12:0]                   vidAddr,
  output logic                          prgRomSel,
  output logic [$clog2(PRG_BANKS)+12:0] prgRomAddr,
  output logic                          prgRamSel,
  output logic [12:0]                   prgRamAddr,
  output logic [$clog2(CHR_BANKS)+9:0]  chrAddr,
  output logic                          mirrorHorz
);
  ctrlStrobes_t strobes;

  cbm_ctrl uCtrl (
    .cpuWrEn       (cpuWrEn),
    .cpuAddr       (cpuAddr),
    .cpuData       (cpuData),
    .fourScreenCfg (fourScreenCfg),
    .strobes       (strobes)
  );

  cbm_dpath #(
    .PRG_BANKS (PRG_BANKS),
    .CHR_BANKS (CHR_BANKS)
  ) uDpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .cpuAddr    (cpuAddr),
    .vidAddr    (vidAddr),
    .prgRomSel  (prgRomSel),
    .prgRomAddr (prgRomAddr),
    .prgRamSel  (prgRamSel),
    .prgRamAddr (prgRamAddr),
    .chrAddr    (chrAddr),
    .mirrorHorz (mirrorHorz)
  );
endmodule

// File: rtl/cbm_checker.sv
module cbm_checker #(
  parameter int PRG_BANKS = 16,
  parameter int CHR_BANKS = 128
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          cpuWrEn,
  input logic [15:0]                   cpuAddr,
  input logic [7:0]                    cpuData,
  input logic                          fourScreenCfg,
  input logic [12:0]                   vidAddr,
  input logic                          prgRomSel,
  input logic [$clog2(PRG_BANKS)+12:0] prgRomAddr,
  input logic                          prgRamSel,
  input logic [12:0]                   prgRamAddr,
  input logic [$clog2(CHR_BANKS)+9:0]  chrAddr,
  input logic                          mirrorHorz
);
  localparam int PW = $clog2(PRG_BANKS) + 13;

  AST_PRG_OFFSET: assert property (@(posedge clk) disable iff (!rstN)
    prgRomSel |-> (prgRomAddr[12:0] == cpuAddr[12:0])); // R4

  AST_LAST_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAddr[15:13] == 3'b111) |-> (&prgRomAddr[PW-1:13])); // R5

  AST_CHR_OFFSET: assert property (@(posedge clk) disable iff (!rstN)
    chrAddr[9:0] == vidAddr[9:0]); // R6

  AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(prgRomSel && prgRamSel)); // R12

  AST_FOURSCREEN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (fourScreenCfg && $past(fourScreenCfg)) |-> $stable(mirrorHorz)); // R9

  AST_LOW_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cpuWrEn && !cpuAddr[15]) && $stable(vidAddr)) |-> $stable(chrAddr)); // R12

  AST_IRQ_RANGE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cpuWrEn && (cpuAddr[15:14] == 2'b11)) && $stable(vidAddr))
      |-> ($stable(chrAddr) && $stable(mirrorHorz))); // R10
endmodule

bind cart_bank_map cbm_checker #(
  .PRG_BANKS (PRG_BANKS),
  .CHR_BANKS (CHR_BANKS)
) uChk (.*);

// File: tb/cart_bank_map_test.sv
`timescale 1ns/1ps
module cart_bank_map_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuWrEn = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [7:0]  cpuData = '0;
  logic        fourScreenCfg = 1'b0;
  logic [12:0] vidAddr = '0;
  logic        prgRomSel;
  logic [16:0] prgRomAddr;
  logic        prgRamSel;
  logic [12:0] prgRamAddr;
  logic [16:0] chrAddr;
  logic        mirrorHorz;

  always #4 clk = ~clk;

  cart_bank_map uut (
    .clk(clk), .rstN(rstN), .cpuWrEn(cpuWrEn), .cpuAddr(cpuAddr),
    .cpuData(cpuData), .fourScreenCfg(fourScreenCfg), .vidAddr(vidAddr),
    .prgRomSel(prgRomSel), .prgRomAddr(prgRomAddr), .prgRamSel(prgRamSel),
    .prgRamAddr(prgRamAddr), .chrAddr(chrAddr), .mirrorHorz(mirrorHorz)
  );

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 1'b0;

  // monitor: compare queued expectations away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        case (it.kind)
          0:       act = 32'(prgRomAddr);
          1:       act = 32'(chrAddr);
          2:       act = 32'(mirrorHorz);
          default: act = 32'({prgRomSel, prgRamSel, prgRamAddr});
        endcase
        checkCnt++;
        if (act !== it.exp) begin
          failCnt++;
          $display("FAIL %s: actual 0x%0h expected 0x%0h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpuWrEn = 1'b1; cpuAddr = a; cpuData = d;
    @(negedge clk);
    cpuWrEn = 1'b0;
  endtask

  task automatic expPrg(input logic [15:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    cpuAddr = a;
    q.push_back('{0, e, t});
  endtask

  task automatic expChr(input logic [12:0] v, input logic [31:0] e, input string t);
    @(negedge clk);
    vidAddr = v;
    q.push_back('{1, e, t});
  endtask

  task automatic expMir(input logic [31:0] e, input string t);
    @(negedge clk);
    q.push_back('{2, e, t});
  endtask

  task automatic expSel(input logic [15:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    cpuAddr = a;
    q.push_back('{3, e, t});
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog: actual hung expected finished");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R11 reset defaults
    expPrg(16'h8123, 32'h00123, "R11 win0 after reset");
    expPrg(16'hC456, 32'h1C456, "R11 win2 second-last");
    expPrg(16'hE789, 32'h1E789, "R11 win3 last");
    expChr(13'h1C05, 32'h00005, "R11 slot7 bank0");
    expMir(32'd0, "R11 mirror vertical");

    // R2 R3 R4 R13
    wr(16'h8000, 8'h06);
    wr(16'h8001, 8'h05);
    expPrg(16'h8123, 32'h0A123, "R3 R4 win0 uses reg6");
    wr(16'h8000, 8'h07);
    wr(16'h8001, 8'h23);
    expPrg(16'hA010, 32'h06010, "R13 R4 win1 reg7 masked");

    // R5 program mode 1
    wr(16'h8000, 8'h46);
    expPrg(16'h8001, 32'h1C001, "R5 win0 second-last");
    expPrg(16'hC002, 32'h0A002, "R5 win2 uses reg6");
    expPrg(16'hA003, 32'h06003, "R5 win1 still reg7");
    expPrg(16'hE004, 32'h1E004, "R5 win3 last");

    // R1 mirror addresses, R6 inversion 0
    wr(16'h9FFE, 8'h00);
    wr(16'h9FFF, 8'h11);
    expPrg(16'h8123, 32'h0A123, "R1 R2 select via 9FFE mode0");
    expChr(13'h0003, 32'h04003, "R1 R6 slot0 even of reg0");
    expChr(13'h0400, 32'h04400, "R6 slot1 odd of reg0");
    wr(16'h8000, 8'h01); wr(16'h8001, 8'h08);
    wr(16'h8000, 8'h02); wr(16'h8001, 8'h20);
    wr(16'h8000, 8'h03); wr(16'h8001, 8'h21);
    wr(16'h8000, 8'h04); wr(16'h8001, 8'h7F);
    wr(16'h8000, 8'h05); wr(16'h8001, 8'hFF);
    expChr(13'h0800, 32'h02000, "R6 slot2 reg1 even");
    expChr(13'h0C00, 32'h02400, "R6 slot3 reg1 odd");
    expChr(13'h1000, 32'h08000, "R6 slot4 reg2");
    expChr(13'h1400, 32'h08400, "R6 slot5 reg3");
    expChr(13'h1C00, 32'h1FC00, "R6 R13 slot7 reg5 masked");

    // R7 inversion 1
    wr(16'h8000, 8'h80);
    expChr(13'h0000, 32'h08000, "R7 slot0 reg2");
    expChr(13'h0C00, 32'h1FC00, "R7 slot3 reg5");
    expChr(13'h1000, 32'h04000, "R7 slot4 reg0 even");
    expChr(13'h1C00, 32'h02400, "R7 slot7 reg1 odd");

    // R8 R9 R10 mirroring and ignored writes
    wr(16'hA000, 8'h01);
    expMir(32'd1, "R8 mirror horizontal");
    wr(16'hA001, 8'h00);
    expMir(32'd1, "R10 A001 ignored");
    wr(16'hC000, 8'h00);
    wr(16'hC001, 8'h00);
    wr(16'hE000, 8'h00);
    wr(16'hE001, 8'hFF);
    expMir(32'd1, "R10 C000-FFFF no mirror change");
    expChr(13'h0000, 32'h08000, "R10 C000-FFFF no chr change");
    expPrg(16'h8123, 32'h0A123, "R10 C000-FFFF no prg change");
    fourScreenCfg = 1'b1;
    wr(16'hA000, 8'h00);
    expMir(32'd1, "R9 four-screen blocks mirror");
    fourScreenCfg = 1'b0;
    wr(16'hA000, 8'h00);
    expMir(32'd0, "R8 mirror vertical");
    wr(16'hBFFE, 8'h01);
    expMir(32'd1, "R1 BFFE acts as A000");

    // R12 RAM window and low writes
    expSel(16'h6ABC, 32'h02ABC, "R12 RAM window select");
    expSel(16'h5000, 32'h01000, "R12 below RAM no select");
    expSel(16'h9000, 32'h05000, "R12 ROM select");
    wr(16'h7FFF, 8'h47);
    wr(16'h6001, 8'h12);
    expPrg(16'h8123, 32'h0A123, "R12 low write no prg change");
    expChr(13'h1C00, 32'h02400, "R12 low write no chr change");

    // R11 reset mid-run
    @(negedge clk);
    rstN = 1'b0;
    expPrg(16'h8123, 32'h00123, "R11 reset clears reg6");
    expMir(32'd0, "R11 reset clears mirror");
    expChr(13'h0400, 32'h00400, "R11 reset slot1 bank1");
    @(negedge clk);
    rstN = 1'b1;

    repeat (3) @(negedge clk);
    done = 1'b1;
    finishRun();
  end
endmodule